// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status byte of a small 8-bit processor core. Three of its bits are arithmetic flags: zero, nibble carry and carry. They are computed from the operands and the operation that the ALU performs in the same cycle. Two more bits record why the core last reset or woke up. They are driven only by event strobes for power-up, watchdog clear, sleep entry and watchdog timeout. The top three bits are not implemented and read as zero.

Software can also name the register as the destination of an instruction. A plain move or bit operation writes the three flag bits directly. When the same instruction also updates the flags, the flag logic wins and the write data for those bits is dropped. The two reset-cause bits never take write data. A flag-updating clear therefore leaves Z set, leaves the upper bits zero and leaves every other bit unchanged. The output is the registered status byte.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset the status byte reads 0x18: time-out bit (bit 4) and power-down bit (bit 3) are 1, and zero (bit 2), nibble carry (bit 1) and carry (bit 0) are 0.
- R2: Bits 7 to 5 always read 0, including after a write of 0xFF.
- R3: When flags update (flag_en=1), bit 2 becomes 1 exactly when the 8-bit operation result is zero.
- R4: For add (op code 0), bit 0 is the carry out of bit 7 of a+b, and bit 1 is the carry out of bit 3.
- R5: For subtract (op code 1), the result is a + ~b + 1. Bit 0 is 1 when a >= b and bit 1 is 1 when a[3:0] >= b[3:0], so both bits read as an inverted borrow.
- R6: For the logic operations AND (2), OR (3) and XOR (4), only bit 2 is updated, and bits 1 and 0 keep their values.
- R7: When wr_en and flag_en are both 1, the write data for bits 2 to 0 is discarded and the flag logic sets those bits.
- R8: A write with flag_en=0 loads wr_data[2:0] into bits 2 to 0 and leaves bits 4 and 3 unchanged.
- R9: A flag-updating clear (write of 0 together with an AND of zeros) leaves the pattern 000u_u1uu.
- R10: Watchdog timeout clears bit 4. Sleep sets bit 4 and clears bit 3. Watchdog clear and power-up set both bits.
- R11: When events coincide, priority runs power-up, then timeout, then sleep, then watchdog clear. Only the highest pending event acts, and a timeout leaves bit 3 unchanged.
- R12: With no write, no flag update and no event, the byte holds its value.
- R13: Op codes 5 to 7 pass operand a as the result and update only bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_op | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5-7 pass a |
| flag_en | input | 1 | Instruction updates the arithmetic flags |
| wr_en | input | 1 | Instruction writes the status register |
| wr_data | input | 8 | Write data |
| evt_pwrup | input | 1 | Power-up strobe |
| evt_wdt_clr | input | 1 | Watchdog clear strobe |
| evt_sleep | input | 1 | Sleep entry strobe |
| evt_wdt_tmo | input | 1 | Watchdog timeout strobe |
| status_q | output | 8 | Registered status byte |

## Verification
On every cycle the assertions check that an idle cycle holds the byte and that a plain write lands in the flag bits. They also check that logic operations leave both carry bits alone and that each single event moves the reset-cause bits the right way. The carry and nibble-carry values over all operand pairs, the priority among coinciding events and the clear pattern can be shown only by the bench's scenarios. The bench sweeps every add and subtract operand pair and compares against arithmetic it computes itself.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PASS = 3'd5
  } alu_op_e;

  localparam int ST_W  = 8;
  localparam int ST_TO = 4;
  localparam int ST_PD = 3;
  localparam int ST_Z  = 2;
  localparam int ST_DC = 1;
  localparam int ST_C  = 0;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
    logic arith;
  } flag_res_t;
endpackage

// File: rtl/status_flag_calc.sv
module status_flag_calc
  import status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  output flag_res_t         res
);
  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] result;

  always_comb begin
    is_sub = (op == ALU_SUB);
    b_eff  = is_sub ? ~b : b;
    sum    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
    res.arith = 1'b0;
    case (op)
      ALU_ADD, ALU_SUB: begin
        result    = sum[DATA_W-1:0];
        res.arith = 1'b1;
      end
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_XOR: result = a ^ b;
      default: result = a;
    endcase
    res.z  = ~|result;
    res.c  = sum[DATA_W];
    // carry into bit NIB_W, recovered from the sum bit and the two operand bits
    res.dc = sum[NIB_W] ^ a[NIB_W] ^ b_eff[NIB_W];
  end
endmodule

// File: rtl/status_cause_track.sv
module status_cause_track (
  input  logic to_cur,
  input  logic pd_cur,
  input  logic evt_pwrup,
  input  logic evt_wdt_clr,
  input  logic evt_sleep,
  input  logic evt_wdt_tmo,
  output logic to_nx,
  output logic pd_nx
);
  always_comb begin
    to_nx = to_cur;
    pd_nx = pd_cur;
    if (evt_pwrup) begin
      to_nx = 1'b1;
      pd_nx = 1'b1;
    end else if (evt_wdt_tmo) begin
      to_nx = 1'b0;
    end else if (evt_sleep) begin
      to_nx = 1'b1;
      pd_nx = 1'b0;
    end else if (evt_wdt_clr) begin
      to_nx = 1'b1;
      pd_nx = 1'b1;
    end
  end
endmodule

// File: rtl/status_flag_merge.sv
module status_flag_merge
  import status_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] cur,
  input  logic              flag_en,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_bits,
  input  flag_res_t         res,
  output logic [FLAG_W-1:0] nx
);
  always_comb begin
    nx = cur;
    if (flag_en) begin
      nx[ST_Z] = res.z;
      if (res.arith) begin
        nx[ST_DC] = res.dc;
        nx[ST_C]  = res.c;
      end
    end else if (wr_en) begin
      nx = wr_bits;
    end
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic [2:0]        alu_op,
  input  logic              flag_en,
  input  logic              wr_en,
  input  logic [ST_W-1:0]   wr_data,
  input  logic              evt_pwrup,
  input  logic              evt_wdt_clr,
  input  logic              evt_sleep,
  input  logic              evt_wdt_tmo,
  output logic [ST_W-1:0]   status_q
);
  localparam int FLAG_W = ST_Z + 1;
  localparam int USED_W = ST_TO + 1;

  flag_res_t         res;
  logic [FLAG_W-1:0] flags_q, flags_nx;
  logic              to_q, pd_q, to_nx, pd_nx;

  status_flag_calc #(.DATA_W(DATA_W), .NIB_W(NIB_W)) calc_i (
    .a(alu_a), .b(alu_b), .op(alu_op), .res(res)
  );

  status_flag_merge #(.FLAG_W(FLAG_W)) merge_i (
    .cur(flags_q), .flag_en(flag_en), .wr_en(wr_en),
    .wr_bits(wr_data[FLAG_W-1:0]), .res(res), .nx(flags_nx)
  );

  status_cause_track cause_i (
    .to_cur(to_q), .pd_cur(pd_q),
    .evt_pwrup(evt_pwrup), .evt_wdt_clr(evt_wdt_clr),
    .evt_sleep(evt_sleep), .evt_wdt_tmo(evt_wdt_tmo),
    .to_nx(to_nx), .pd_nx(pd_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      to_q    <= 1'b1;
      pd_q    <= 1'b1;
    end else begin
      flags_q <= flags_nx;
      to_q    <= to_nx;
      pd_q    <= pd_nx;
    end
  end

  always_comb begin
    status_q              = '0;
    status_q[FLAG_W-1:0]  = flags_q;
    status_q[ST_PD]       = pd_q;
    status_q[ST_TO]       = to_q;
  end

  // unimplemented positions are tied low
  for (genvar gi = USED_W; gi < ST_W; gi++) begin : g_unimpl
    logic unused_wr;
    assign unused_wr = wr_data[gi];
  end
endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] alu_op,
  input logic       flag_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       evt_pwrup,
  input logic       evt_wdt_clr,
  input logic       evt_sleep,
  input logic       evt_wdt_tmo,
  input logic [7:0] status_q
);
  logic any_evt;
  assign any_evt = evt_pwrup | evt_wdt_clr | evt_sleep | evt_wdt_tmo;

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !flag_en && !any_evt) |=> $stable(status_q));

  assert_plain_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flag_en) |=> (status_q[2:0] == $past(wr_data[2:0])));

  assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_en && (alu_op == 3'd2 || alu_op == 3'd3 || alu_op == 3'd4))
      |=> $stable(status_q[1:0]));

  assert_tmo_clears_to_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_wdt_tmo && !evt_pwrup) |=> !status_q[4]);

  assert_sleep_sets_pattern_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_sleep && !evt_pwrup && !evt_wdt_tmo) |=> (status_q[4:3] == 2'b10));

  assert_cause_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !any_evt |=> $stable(status_q[4:3]));
endmodule

bind cpu_status_reg status_reg_chk chk_i (
  .clk(clk), .rst(rst), .alu_op(alu_op), .flag_en(flag_en), .wr_en(wr_en),
  .wr_data(wr_data), .evt_pwrup(evt_pwrup), .evt_wdt_clr(evt_wdt_clr),
  .evt_sleep(evt_sleep), .evt_wdt_tmo(evt_wdt_tmo), .status_q(status_q)
);

// File: tb/cpu_status_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] alu_a = '0, alu_b = '0, wr_data = '0;
  logic [2:0] alu_op = '0;
  logic       flag_en = 1'b0, wr_en = 1'b0;
  logic       evt_pwrup = 1'b0, evt_wdt_clr = 1'b0, evt_sleep = 1'b0, evt_wdt_tmo = 1'b0;
  logic [7:0] status_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] exp_q = 8'h18;

  always #2 clk = ~clk;

  cpu_status_reg dut_i (
    .clk(clk), .rst(rst), .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op),
    .flag_en(flag_en), .wr_en(wr_en), .wr_data(wr_data),
    .evt_pwrup(evt_pwrup), .evt_wdt_clr(evt_wdt_clr), .evt_sleep(evt_sleep),
    .evt_wdt_tmo(evt_wdt_tmo), .status_q(status_q)
  );

  task automatic check(input string tag);
    checks++;
    if (status_q !== exp_q) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, status_q, exp_q);
    end
  endtask

  // ev = {pwrup, tmo, sleep, clr}
  task automatic step(input string tag, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] op, input logic fe, input logic we,
                      input logic [7:0] wd, input logic [3:0] ev);
    int r, z, dc, c, t, p;
    z = exp_q[2]; dc = exp_q[1]; c = exp_q[0]; t = exp_q[4]; p = exp_q[3];
    if (fe) begin
      case (op)
        3'd0: begin r = (a + b) % 256; c = (a + b) > 255; dc = (a % 16 + b % 16) > 15; end
        3'd1: begin r = (256 + a - b) % 256; c = (a >= b); dc = (a % 16 >= b % 16); end
        3'd2: r = a & b;
        3'd3: r = a | b;
        3'd4: r = a ^ b;
        default: r = a;
      endcase
      z = (r == 0);
    end else if (we) begin
      z = wd[2]; dc = wd[1]; c = wd[0];
    end
    if (ev[3]) begin t = 1; p = 1; end
    else if (ev[2]) t = 0;
    else if (ev[1]) begin t = 1; p = 0; end
    else if (ev[0]) begin t = 1; p = 1; end
    exp_q = {3'b000, t[0], p[0], z[0], dc[0], c[0]};
    alu_a = a; alu_b = b; alu_op = op; flag_en = fe; wr_en = we; wr_data = wd;
    {evt_pwrup, evt_wdt_tmo, evt_sleep, evt_wdt_clr} = ev;
    @(posedge clk);
    @(negedge clk);
    check(tag);
    flag_en = 0; wr_en = 0;
    {evt_pwrup, evt_wdt_tmo, evt_sleep, evt_wdt_clr} = 4'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset");
    step("R2 write ff", 0, 0, 0, 0, 1, 8'hFF, 0);
    step("R8 write 05", 0, 0, 0, 0, 1, 8'h05, 0);
    step("R12 idle", 8'h00, 8'h00, 0, 0, 0, 0, 0);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step("R4 add", a[7:0], b[7:0], 3'd0, 1, 0, 0, 0);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step("R5 sub", a[7:0], b[7:0], 3'd1, 1, 0, 0, 0);
    for (int op = 2; op < 5; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17) begin
          if (b == 0) step("R8 preset", 0, 0, 0, 0, 1, {6'b0, a[1:0]}, 0);
          step("R6 logic", a[7:0], b[7:0], op[2:0], 1, 0, 0, 0);
        end
    step("R3 zero sub", 8'h40, 8'h40, 3'd1, 1, 0, 0, 0);
    step("R7 masked", 8'h01, 8'h01, 3'd0, 1, 1, 8'h07, 0);
    step("R7 masked2", 8'hF0, 8'h10, 3'd0, 1, 1, 8'h00, 0);
    step("R8 preset", 0, 0, 0, 0, 1, 8'h03, 0);
    step("R9 clear", 8'h00, 8'h00, 3'd2, 1, 1, 8'h00, 0);
    for (int op = 5; op < 8; op++) begin
      step("R13 pass zero", 8'h00, 8'hFF, op[2:0], 1, 0, 0, 0);
      step("R13 pass nz", 8'h80, 8'h80, op[2:0], 1, 0, 0, 0);
    end
    step("R10 tmo", 0, 0, 0, 0, 0, 0, 4'b0100);
    step("R10 sleep", 0, 0, 0, 0, 0, 0, 4'b0010);
    step("R10 wdt clr", 0, 0, 0, 0, 0, 0, 4'b0001);
    step("R10 sleep2", 0, 0, 0, 0, 0, 0, 4'b0010);
    step("R10 pwrup", 0, 0, 0, 0, 0, 0, 4'b1000);
    step("R11 pwrup+tmo", 0, 0, 0, 0, 0, 0, 4'b1100);
    step("R11 tmo+sleep", 0, 0, 0, 0, 0, 0, 4'b0110);
    step("R11 tmo+sleep+clr", 0, 0, 0, 0, 0, 0, 4'b0111);
    step("R11 sleep+clr", 0, 0, 0, 0, 0, 0, 4'b0011);
    step("R11 write no touch", 0, 0, 0, 0, 1, 8'h18, 0);
    step("R12 idle2", 8'h12, 8'h34, 3'd0, 0, 0, 0, 0);
    step("R8 preset", 0, 0, 0, 0, 1, 8'h07, 0);
    rst = 1;
    exp_q = 8'h18;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset again");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule